// File: doc/BRIEF.md
# HDLC Receive Byte FIFO with Packet-Boundary Accounting

This block buffers received HDLC payload bytes between a bit-level deframer and a host that reads one byte at a time. The deframer hands over each byte with a start marker, an end marker and, on the final byte of a frame, a two-bit end code. The block stores up to 64 bytes. It tells the host how many bytes it may read before it crosses the next frame boundary, and whether those bytes close a frame or are only part of one that is still arriving.

A programmable threshold drives a live high-fill flag that the host can use to start draining. When the buffer cannot take a byte, the frame in progress is lost. The whole store and every pending end code are flushed, and the event is reported twice: through the end-code path with its own code, and through a sticky flag that the host clears. After a flush, bytes are thrown away until the deframer signals the start of a new frame. Each frame's end code is kept in a small side queue and handed to the host when the host reads the frame's last byte.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: Accepted bytes are returned to the host in the order they were accepted, and up to 64 bytes can be held at once.
- R2: The low 7 bits of `bytes_avail` give the number of stored bytes from the oldest byte up to and including the first stored byte that carried an end marker. If no stored byte carries an end marker, they give the total number of stored bytes (0 to 64).
- R3: Bit 7 of `bytes_avail` is 1 when at least one byte is stored and no stored byte carries an end marker. Otherwise it is 0.
- R4: `wm_high` is an unlatched level that is 1 exactly while the stored byte count is strictly greater than `wm_level` (0 to 63). It follows the count in the same cycle as the count changes.
- R5: An overrun occurs when a byte is accepted while 64 bytes are stored, or when an end-marked byte is accepted while SQ_DEPTH (default 16) end codes are already pending. On an overrun the byte is dropped, all stored bytes and pending end codes are discarded, and `bytes_avail` reads 0 on the next cycle. A read requested in the same cycle is not performed and returns 0.
- R6: After an overrun, bytes without `in_sop` are ignored. The next byte with `in_sop` is accepted as the first byte of a new frame. Out of reset, bytes are accepted without waiting for a start marker.
- R7: `ovr_latched` is set by an overrun and stays set until `ovr_clear` is high in a cycle with no new overrun. If both happen in the same cycle, the overrun wins.
- R8: One cycle after the host reads a frame's end-marked byte, `pkt_done` pulses for one cycle. `pkt_status` then shows the code that came with that byte: 0 good, 1 CRC error, 2 abort. One cycle after an overrun, `pkt_done` pulses with `pkt_status` = 3.
- R9: When `rd_en` is high and bytes are stored, `rd_data` shows the oldest byte on the next cycle. When `rd_en` is high and the FIFO is empty, `rd_data` becomes 0 and nothing else changes. `rd_data` holds its value while `rd_en` is low.
- R10: After reset, `rd_data`, `bytes_avail`, `wm_high`, `pkt_done`, `pkt_status` and `ovr_latched` are all 0.
- R11: A write and a read in the same cycle are both performed, so the stored count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte from the deframer is present |
| in_data | input | 8 | Received byte |
| in_sop | input | 1 | Byte is the first byte of a frame |
| in_eop | input | 1 | Byte is the last byte of a frame |
| in_status | input | 2 | End code, used only with in_eop (0 good, 1 CRC error, 2 abort) |
| wm_level | input | 6 | High-fill threshold in bytes |
| rd_en | input | 1 | Host reads one byte |
| rd_data | output | 8 | Byte read, valid the cycle after rd_en |
| bytes_avail | output | 8 | Bit 7 partial-frame flag, bits 6:0 readable count |
| wm_high | output | 1 | Fill level above threshold |
| pkt_done | output | 1 | One-cycle pulse: frame end reached by host, or overrun |
| pkt_status | output | 2 | End code for the last pkt_done (3 = overrun) |
| ovr_latched | output | 1 | Sticky overrun indication |
| ovr_clear | input | 1 | Clears ovr_latched |

## Verification
The embedded properties check, on every cycle, that the fill level never passes the depth and that an overrun always leaves the store empty. They also check that a partial-frame report always covers every stored byte, that an empty read returns zero, that discarded bytes never move the write pointer, and that the overrun flag stays set until it is cleared. The order of the bytes, the exact count to the next frame boundary, and the pairing of each end code with its own frame depend on whole sequences. Only the bench's frame-level scenarios can show these, as can the exact threshold crossing and the flush of a side queue that has filled up.

// File: rtl/hrf_pkg.sv
// Shared types for the HDLC receive FIFO.
// Assumes a two-bit end code; value 3 is reserved for overrun reports.
package hrf_pkg;
    typedef enum logic [1:0] {
        ST_GOOD  = 2'd0,
        ST_CRC   = 2'd1,
        ST_ABORT = 2'd2,
        ST_OVR   = 2'd3
    } pkt_st_e;
endpackage

// File: rtl/hrf_byte_store.sv
// Byte storage array for the receive FIFO.
// One synchronous write port and one asynchronous read port.
// Assumes the controller only writes and reads valid addresses; the content has no reset.
module hrf_byte_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write an accepted byte into its slot.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the byte at the head of the FIFO.
    assign rdata = mem[raddr];
endmodule

// File: rtl/hrf_end_queue.sv
// Side queue of frame-end records: the write-pointer value of each end-marked
// byte and the end code that came with it.
// Assumes the caller never pushes when full (that case is turned into an
// overrun) and never pops when empty. A flush empties the queue; a push or pop
// in the same cycle is ignored.
module hrf_end_queue #(
    parameter int QD  = 16,
    parameter int PW  = 7,
    parameter int QAW = (QD > 1) ? $clog2(QD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [PW-1:0]     push_ptr,
    input  hrf_pkg::pkt_st_e  push_st,
    input  logic              pop,
    output logic [PW-1:0]     head_ptr,
    output hrf_pkg::pkt_st_e  head_st,
    output logic              empty,
    output logic              full
);
    logic [PW-1:0]    ptr_mem [QD];
    hrf_pkg::pkt_st_e st_mem  [QD];
    logic [QAW-1:0]   hd_q, tl_q;
    logic [QAW:0]     cnt_q;

    // Advance an index with wrap at the queue depth.
    function automatic logic [QAW-1:0] nxt(input logic [QAW-1:0] i);
        return (i == QAW'(QD - 1)) ? '0 : i + QAW'(1);
    endfunction

    // Store a new end record at the tail.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            ptr_mem[tl_q] <= push_ptr;
            st_mem[tl_q]  <= push_st;
        end
    end

    // Maintain head, tail and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) tl_q <= nxt(tl_q);
            if (pop)  hd_q <= nxt(hd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_ptr = ptr_mem[hd_q];
    assign head_st  = st_mem[hd_q];
    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == (QAW+1)'(QD));

    // R5: a full side queue must never take another record.
    a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push && !flush |-> !full);
    // R8: a record is only handed out when one is pending.
    a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !flush |-> !empty);
endmodule

// File: rtl/hrf_avail_calc.sv
// Computes the host-visible readable count and the partial-frame flag.
// If a frame-end record is pending, the count runs from the read pointer to
// that end byte inclusive. Otherwise it is the whole fill level.
// Assumes pointers are one bit wider than the address so a fill of DEPTH is representable.
module hrf_avail_calc #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rptr,
    input  logic [PW-1:0] fill,
    input  logic          end_pending,
    input  logic [PW-1:0] end_ptr,
    output logic [PW:0]   avail
);
    logic [PW-1:0] count;
    logic          partial;

    // Choose the distance to the first frame end, or the full fill level.
    always_comb begin
        if (end_pending) begin
            count   = end_ptr - rptr + PW'(1);
            partial = 1'b0;
        end else begin
            count   = fill;
            partial = (fill != '0);
        end
    end

    assign avail = {partial, count};

    // R2: the host is never offered more bytes than are stored.
    a_r2_count_le_fill: assert property (@(posedge clk) disable iff (!rst_n)
        avail[PW-1:0] <= fill);
    // R3: a partial-frame report always covers every stored byte.
    a_r3_partial_all: assert property (@(posedge clk) disable iff (!rst_n)
        avail[PW] |-> avail[PW-1:0] == fill);
endmodule

// File: rtl/hdlc_rx_fifo.sv
// HDLC receive FIFO top level.
// Accepts deframed bytes tagged with start and end markers, stores them,
// reports the readable count to the next frame boundary, drives a live
// high-fill flag, and flushes everything on overrun.
// Assumes a single clock, synchronous active-low reset, and that the host
// reads at most one byte per cycle.
module hdlc_rx_fifo #(
    parameter int DEPTH    = 64,
    parameter int SQ_DEPTH = 16,
    parameter int AW       = $clog2(DEPTH),
    parameter int PW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [1:0]    in_status,
    input  logic [AW-1:0] wm_level,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic [PW:0]   bytes_avail,
    output logic          wm_high,
    output logic          pkt_done,
    output logic [1:0]    pkt_status,
    output logic          ovr_latched,
    input  logic          ovr_clear
);
    import hrf_pkg::*;

    logic [PW-1:0] wptr, rptr, fill;
    logic          discard;
    logic          accept, overrun, do_wr, do_rd, head_hit, full;
    logic [7:0]    mem_rdata;
    logic [PW-1:0] q_head_ptr;
    pkt_st_e       q_head_st;
    logic          q_empty, q_full;
    pkt_st_e       st_q;

    // Decide per cycle whether the byte is taken, dropped, or overruns.
    always_comb begin
        fill     = wptr - rptr;
        full     = (fill == PW'(DEPTH));
        accept   = in_valid && (!discard || in_sop);
        overrun  = accept && (full || (in_eop && q_full));
        do_wr    = accept && !overrun;
        do_rd    = rd_en && (fill != '0) && !overrun;
        head_hit = do_rd && !q_empty && (q_head_ptr == rptr);
    end

    hrf_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (do_wr),
        .waddr (wptr[AW-1:0]),
        .wdata (in_data),
        .raddr (rptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    hrf_end_queue #(.QD(SQ_DEPTH), .PW(PW)) u_endq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (overrun),
        .push     (do_wr && in_eop),
        .push_ptr (wptr),
        .push_st  (pkt_st_e'(in_status)),
        .pop      (head_hit),
        .head_ptr (q_head_ptr),
        .head_st  (q_head_st),
        .empty    (q_empty),
        .full     (q_full)
    );

    hrf_avail_calc #(.PW(PW)) u_avail (
        .clk         (clk),
        .rst_n       (rst_n),
        .rptr        (rptr),
        .fill        (fill),
        .end_pending (!q_empty),
        .end_ptr     (q_head_ptr),
        .avail       (bytes_avail)
    );

    // Move the pointers; an overrun empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || overrun) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_wr) wptr <= wptr + PW'(1);
            if (do_rd) rptr <= rptr + PW'(1);
        end
    end

    // Track the drop-until-start state after an overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)                 discard <= 1'b0;
        else if (overrun)           discard <= 1'b1;
        else if (accept && in_sop)  discard <= 1'b0;
    end

    // Register the host read data; an empty read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_en)  rd_data <= do_rd ? mem_rdata : 8'h00;
    end

    // Pulse the frame-end report and hold its code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_done <= 1'b0;
            st_q     <= ST_GOOD;
        end else begin
            pkt_done <= overrun || head_hit;
            if (overrun)       st_q <= ST_OVR;
            else if (head_hit) st_q <= q_head_st;
        end
    end

    // Hold the sticky overrun flag until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovr_latched <= 1'b0;
        else if (overrun)    ovr_latched <= 1'b1;
        else if (ovr_clear)  ovr_latched <= 1'b0;
    end

    assign pkt_status = st_q;
    assign wm_high    = fill > {1'b0, wm_level};

    // R1: the fill level never exceeds the depth.
    a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));
    // R5: an overrun leaves the store empty.
    a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> fill == '0);
    // R6: a byte without a start marker is not stored while discarding.
    a_r6_discard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        discard && in_valid && !in_sop |=> $stable(wptr));
    // R7: the overrun flag is sticky until cleared.
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_latched && !ovr_clear |=> ovr_latched);
    // R9: a read of an empty FIFO returns zero.
    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && fill == '0 |=> rd_data == 8'h00);
    // R4: the high-fill flag implies stored data.
    a_r4_wm_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        wm_high |-> fill != '0);
endmodule

// File: tb/hdlc_rx_fifo_tb_top.sv
// Self-checking bench: a frame-level reference model in bench code, directed
// corner cases, then seeded random traffic in phases of varying read pressure.
module hdlc_rx_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int SQD        = 16;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] in_status = '0;
    logic [5:0] wm_level = '0;
    logic       rd_en = 1'b0, ovr_clear = 1'b0;
    logic [7:0] rd_data, bytes_avail;
    logic       wm_high, pkt_done, ovr_latched;
    logic [1:0] pkt_status;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;

    // Reference model state.
    logic [7:0] qd[$];
    bit         qe[$];
    logic [1:0] qs[$];
    bit         m_discard = 1'b0, m_ovr = 1'b0, m_done = 1'b0;
    logic [7:0] m_rd = '0;
    logic [1:0] m_st = '0;

    hdlc_rx_fifo #(.DEPTH(DEPTH), .SQ_DEPTH(SQD)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_status(in_status),
        .wm_level(wm_level), .rd_en(rd_en), .rd_data(rd_data),
        .bytes_avail(bytes_avail), .wm_high(wm_high), .pkt_done(pkt_done),
        .pkt_status(pkt_status), .ovr_latched(ovr_latched), .ovr_clear(ovr_clear)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected readable count and partial flag from the model queue.
    function automatic logic [7:0] exp_avail();
        for (int i = 0; i < qe.size(); i++)
            if (qe[i]) return {1'b0, 7'(i + 1)};
        if (qd.size() > 0) return {1'b1, 7'(qd.size())};
        return 8'h00;
    endfunction

    function automatic int ends_pending();
        int n = 0;
        for (int i = 0; i < qe.size(); i++) if (qe[i]) n++;
        return n;
    endfunction

    // Update the model with one cycle of stimulus (pre-edge state).
    task automatic model_step(input bit v, input logic [7:0] d, input bit sop,
                              input bit eop, input logic [1:0] st, input bit rd,
                              input bit clr);
        bit acc, ovr;
        acc = v && (!m_discard || sop);
        ovr = acc && (qd.size() == DEPTH || (eop && ends_pending() == SQD));
        m_done = 1'b0;
        if (ovr) begin
            qd.delete(); qe.delete(); qs.delete();
            m_discard = 1'b1; m_ovr = 1'b1; m_done = 1'b1; m_st = 2'd3;
            if (rd) m_rd = 8'h00;
        end else begin
            if (clr) m_ovr = 1'b0;
            if (rd) begin
                if (qd.size() > 0) begin
                    bit e; logic [1:0] s;
                    m_rd = qd.pop_front(); e = qe.pop_front(); s = qs.pop_front();
                    if (e) begin m_done = 1'b1; m_st = s; end
                end else m_rd = 8'h00;
            end
            if (acc) begin
                qd.push_back(d); qe.push_back(eop); qs.push_back(st);
                if (sop) m_discard = 1'b0;
            end
        end
    endtask

    task automatic compare();
        logic [7:0] ea;
        ea = exp_avail();
        check("R1 R9 rd_data", rd_data, m_rd);
        check("R2 avail count", bytes_avail[6:0], ea[6:0]);
        check("R3 partial bit", bytes_avail[7], ea[7]);
        check("R4 wm_high", wm_high, qd.size() > wm_level);
        check("R8 pkt_done", pkt_done, m_done);
        if (m_done) check("R8 pkt_status", pkt_status, m_st);
        check("R7 ovr_latched", ovr_latched, m_ovr);
    endtask

    // Drive one cycle at the falling edge, then compare after the rising edge.
    task automatic apply(input bit v, input logic [7:0] d, input bit sop,
                         input bit eop, input logic [1:0] st, input bit rd,
                         input bit clr);
        @(negedge clk);
        in_valid = v; in_data = d; in_sop = sop; in_eop = eop;
        in_status = st; rd_en = rd; ovr_clear = clr;
        @(posedge clk);
        model_step(v, d, sop, eop, st, rd, clr);
        #1;
        compare();
    endtask

    task automatic drain();
        while (qd.size() > 0) apply(0, 0, 0, 0, 0, 1, 0);
        apply(0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !finished) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int left;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state.
        check("R10 rd_data", rd_data, 0);
        check("R10 bytes_avail", bytes_avail, 0);
        check("R10 wm_high", wm_high, 0);
        check("R10 pkt_done", pkt_done, 0);
        check("R10 pkt_status", pkt_status, 0);
        check("R10 ovr_latched", ovr_latched, 0);

        // R9: empty read returns zero.
        apply(0, 0, 0, 0, 0, 1, 0);

        // R8: single-byte frame with CRC-error code.
        apply(1, 8'hA5, 1, 1, 2'd1, 0, 0);
        check("R2 single byte frame", bytes_avail, 8'h01);
        apply(0, 0, 0, 0, 0, 1, 0);
        check("R8 crc code", pkt_status, 1);

        // R3: partial frame then its end.
        for (int i = 0; i < 5; i++) apply(1, 8'(i + 16), i == 0, 0, 0, 0, 0);
        check("R3 partial five", bytes_avail, 8'h85);
        apply(1, 8'h77, 0, 1, 2'd2, 0, 0);
        check("R2 complete six", bytes_avail, 8'h06);
        drain();

        // R4: watermark boundary at 6.
        wm_level = 6'd6;
        for (int i = 0; i < 7; i++) begin
            apply(1, 8'(i), i == 0, 0, 0, 0, 0);
            check("R4 threshold", wm_high, i == 6);
        end
        // R11: simultaneous read and write keep the count.
        apply(1, 8'h44, 0, 0, 0, 1, 0);
        check("R11 count kept", bytes_avail[6:0], 7);

        // R5: fill to 64, then one more byte overruns.
        wm_level = 6'd63;
        for (int i = 0; i < 57; i++) apply(1, 8'(i + 100), 0, 0, 0, 0, 0);
        check("R1 full count", bytes_avail, 8'hC0);
        check("R4 full above 63", wm_high, 1);
        apply(1, 8'hEE, 0, 0, 0, 1, 0);
        check("R5 flushed", bytes_avail, 0);
        check("R5 read blocked", rd_data, 0);
        // R6: bytes without start marker are ignored.
        for (int i = 0; i < 3; i++) apply(1, 8'h33, 0, i == 2, 0, 0, 0);
        check("R6 ignored", bytes_avail, 0);
        apply(1, 8'h5A, 1, 0, 0, 0, 0);
        check("R6 sop accepted", bytes_avail, 8'h81);
        apply(1, 8'h5B, 0, 1, 0, 0, 0);
        drain();

        // R5: side queue full, 17th end marker overruns.
        for (int i = 0; i < SQD; i++) apply(1, 8'(i), 1, 1, 2'd2, 0, 0);
        check("R2 first of many", bytes_avail, 8'h01);
        apply(1, 8'hFF, 1, 1, 2'd0, 0, 0);
        check("R5 queue overrun", bytes_avail, 0);
        check("R8 overrun code", pkt_status, 3);
        // R7: clear with no new overrun.
        apply(0, 0, 0, 0, 0, 0, 1);
        check("R7 cleared", ovr_latched, 0);

        // Random phases with varying read pressure.
        left = 0;
        for (int ph = 0; ph < 4; ph++) begin
            int wp, rp;
            wp = (ph == 0) ? 60 : (ph == 1) ? 85 : (ph == 2) ? 30 : 95;
            rp = (ph == 0) ? 70 : (ph == 1) ? 20 : (ph == 2) ? 90 : 5;
            wm_level = 6'($urandom % 64);
            for (int c = 0; c < 3000; c++) begin
                bit v, sop, eop;
                v = ($urandom % 100) < wp;
                sop = 1'b0; eop = 1'b0;
                if (v) begin
                    if (left == 0) begin left = 1 + ($urandom % 24); sop = 1'b1; end
                    eop = (left == 1);
                    left--;
                end
                apply(v, 8'($urandom), sop, eop, 2'($urandom % 3),
                      ($urandom % 100) < rp, ($urandom % 40) == 0);
            end
        end
        drain();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule